// File: doc/BRIEF.md
# Synchronous Bus Slave Write Handshake

This block is the slave end of a synchronous processor bus, clocked by the bus clock. It watches three active-low strobes (chip select, read/write direction and write enable). When all three are seen low on one rising edge, it latches a 15-bit address and an 8-bit data byte and starts a write cycle. An active-high ready output tells the master when the write is done. Ready stays low for a fixed number of wait states, then rises on the edge that commits the byte to an internal register array.

Ready stays high for as long as the master keeps the strobes asserted. It falls on the first edge that sees chip select or write enable released, and the slave then returns to idle.

A strobe that is held low can never commit twice. A new write is taken only after an edge on which the strobes were seen released. A strobe that is already low when reset ends is treated the same way: it does not start a write.

The register array stands in for the real target registers. A side port lets one entry be viewed at any time.

Top module: `wsb_write_slave`

## Requirements
- R1: While `rst` is high and on the first edge after it falls, `rdy` is low, and every array entry reads 0.
- R2: A write starts only on a rising edge that samples `cs_n`, `rw_n` and `we_n` all at 0. If any one of them is 1 (for example `rw_n`=1, a read), there is no ready pulse and no array entry changes.
- R3: After the start edge, `rdy` stays low for the next WAIT_CYCLES-1 edges (default 2 wait states in all). It rises on the edge WAIT_CYCLES after the start edge, and it changes only on rising clock edges.
- R4: The array entry is written once, on the edge where `rdy` rises. It takes the address and data sampled on the start edge; later changes on `addr` and `din` have no effect.
- R5: While `rdy` is high and both `cs_n` and `we_n` stay 0, `rdy` stays high. The first edge that sees `cs_n` or `we_n` at 1 drives `rdy` low.
- R6: A new write needs at least one edge on which `cs_n` or `we_n` was seen at 1. Strobes held low after a commit, or held low through the end of reset, cause no further write.
- R7: If `cs_n` or `we_n` is seen at 1 before `rdy` has risen, the cycle is abandoned: `rdy` stays low and no entry changes.
- R8: An entry is selected by a full 15-bit match of `addr` against its index. An address at or above REG_DEPTH still completes the handshake but changes no entry.
- R9: `peek_data` shows, without a clock delay, the entry selected by `peek_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rw_n | input | 1 | Direction; 0 marks a write |
| we_n | input | 1 | Write enable strobe, active low |
| addr | input | ADDR_W (15) | Target address |
| din | input | DATA_W (8) | Write data byte |
| rdy | output | 1 | Ready, active high; high once the write is committed |
| peek_idx | input | clog2(REG_DEPTH) (4) | Array entry to view |
| peek_data | output | DATA_W (8) | Contents of the viewed entry |

## Verification
The hardest case to reach from the ports is a second write caused by a strobe that never lets go. This can happen in two ways: strobes held low long after a commit, or strobes already low when reset ends. The bench creates both. It keeps the strobes low across reset release, and it changes `addr` and `din` while the strobes stay low through the whole ready phase. It then reads the array back to show that exactly one entry holds the first captured byte. Abandoned cycles and out-of-range addresses that only share their low bits with a real entry are also driven, and the whole array is read back after them.

// File: rtl/wsb_pkg.sv
package wsb_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_DONE = 2'd2
   } wsb_state_e;
endpackage

// File: rtl/wsb_strobe_qual.sv
// Qualifies the active-low strobes and keeps the re-arm flag that blocks
// a held strobe from starting a second cycle.
module wsb_strobe_qual (
   input  logic clk,
   input  logic rst,
   input  logic cs_n,
   input  logic rw_n,
   input  logic we_n,
   output logic accept,
   output logic strb_off
);
   logic armed_q;

   assign strb_off = cs_n | we_n;
   assign accept   = armed_q & ~cs_n & ~rw_n & ~we_n;

   always_ff @(posedge clk) begin
      if (rst)           armed_q <= 1'b0;
      else if (strb_off) armed_q <= 1'b1;
      else if (accept)   armed_q <= 1'b0;
   end
endmodule

// File: rtl/wsb_wait_timer.sv
// Down-counter for the wait-state window.
module wsb_wait_timer #(
   parameter int WAIT_CYCLES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic load,
   input  logic step,
   output logic expired
);
   localparam int CNT_W = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(WAIT_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;

   assign expired = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (rst)                  cnt_q <= '0;
      else if (load)            cnt_q <= LOAD_V;
      else if (step && !expired) cnt_q <= cnt_q - 1'b1;
   end
endmodule

// File: rtl/wsb_reg_array.sv
// Stand-in target registers, one full-width address comparator per entry.
module wsb_reg_array #(
   parameter int ADDR_W    = 15,
   parameter int DATA_W    = 8,
   parameter int REG_DEPTH = 16,
   localparam int IDX_W    = (REG_DEPTH > 1) ? $clog2(REG_DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem [REG_DEPTH];

   for (genvar i = 0; i < REG_DEPTH; i++) begin : g_entry
      always_ff @(posedge clk) begin
         if (rst)
            mem[i] <= '0;
         else if (wr_en && (wr_addr == ADDR_W'(i)))
            mem[i] <= wr_data;
      end
   end

   assign rd_data = mem[rd_idx];
endmodule

// File: rtl/wsb_write_slave.sv
module wsb_write_slave #(
   parameter int ADDR_W      = 15,
   parameter int DATA_W      = 8,
   parameter int WAIT_CYCLES = 2,
   parameter int REG_DEPTH   = 16,
   localparam int IDX_W      = (REG_DEPTH > 1) ? $clog2(REG_DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cs_n,
   input  logic              rw_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic              rdy,
   input  logic [IDX_W-1:0]  peek_idx,
   output logic [DATA_W-1:0] peek_data
);
   import wsb_pkg::*;

   if (WAIT_CYCLES < 1) begin : g_bad_wait
      $error("WAIT_CYCLES must be at least 1");
   end
   if (REG_DEPTH < 2 || REG_DEPTH > (1 << ADDR_W)) begin : g_bad_depth
      $error("REG_DEPTH must lie between 2 and the address space size");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   wsb_state_e        state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              accept;
   logic              strb_off;
   logic              expired;
   logic              start;
   logic              commit;

   wsb_strobe_qual u_qual (
      .clk      (clk),
      .rst      (rst),
      .cs_n     (cs_n),
      .rw_n     (rw_n),
      .we_n     (we_n),
      .accept   (accept),
      .strb_off (strb_off)
   );

   wsb_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .load    (start),
      .step    (state_q == ST_WAIT),
      .expired (expired)
   );

   assign start  = accept && (state_q == ST_IDLE);
   assign commit = (state_q == ST_WAIT) && !strb_off && expired;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         data_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start) begin
               state_q <= ST_WAIT;
               addr_q  <= addr;
               data_q  <= din;
            end
            ST_WAIT: begin
               if (strb_off)    state_q <= ST_IDLE;
               else if (commit) state_q <= ST_DONE;
            end
            ST_DONE: if (strb_off) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign rdy = (state_q == ST_DONE);

   wsb_reg_array #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .REG_DEPTH (REG_DEPTH)
   ) u_array (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (commit),
      .wr_addr (addr_q),
      .wr_data (data_q),
      .rd_idx  (peek_idx),
      .rd_data (peek_data)
   );
endmodule

// File: rtl/wsb_write_slave_chk.sv
module wsb_write_slave_chk #(
   parameter int WAIT_CYCLES = 2
) (
   input logic clk,
   input logic rst,
   input logic cs_n,
   input logic we_n,
   input logic rdy,
   input logic commit
);
   localparam int HW = $clog2(WAIT_CYCLES + 2);

   // Counts consecutive edges with both strobes low; saturates.
   logic [HW-1:0] hold_cnt;
   always_ff @(posedge clk) begin
      if (rst || cs_n || we_n)  hold_cnt <= '0;
      else if (hold_cnt != '1)  hold_cnt <= hold_cnt + 1'b1;
   end

   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !rdy);

   p_rise_after_wait_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(rdy) |-> (int'(hold_cnt) > WAIT_CYCLES));

   p_commit_raises_ready_r4: assert property (@(posedge clk) disable iff (rst)
      commit |=> rdy);

   p_ready_needs_strobes_r5: assert property (@(posedge clk) disable iff (rst)
      rdy |-> ($past(cs_n) == 1'b0 && $past(we_n) == 1'b0));

   p_ready_drops_r5: assert property (@(posedge clk) disable iff (rst)
      (rdy && (cs_n || we_n)) |=> !rdy);

   p_single_commit_r6: assert property (@(posedge clk) disable iff (rst)
      commit |=> !commit);
endmodule

bind wsb_write_slave wsb_write_slave_chk #(.WAIT_CYCLES(WAIT_CYCLES)) i_chk (
   .clk    (clk),
   .rst    (rst),
   .cs_n   (cs_n),
   .we_n   (we_n),
   .rdy    (rdy),
   .commit (commit)
);

// File: tb/test_wsb_write_slave.sv
`timescale 1ns/100ps
module test_wsb_write_slave;
   localparam int N     = 2;
   localparam int DEPTH = 16;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cs_n = 1'b1;
   logic        rw_n = 1'b1;
   logic        we_n = 1'b1;
   logic [14:0] addr = '0;
   logic [7:0]  din = '0;
   logic        rdy;
   logic [3:0]  peek_idx = '0;
   logic [7:0]  peek_data;

   int checks = 0;
   int fails  = 0;
   logic [7:0] exp_mem [DEPTH];

   always #4 clk = ~clk;

   wsb_write_slave i_wsb_write_slave (
      .clk(clk), .rst(rst), .cs_n(cs_n), .rw_n(rw_n), .we_n(we_n),
      .addr(addr), .din(din), .rdy(rdy),
      .peek_idx(peek_idx), .peek_data(peek_data)
   );

   task automatic chk_eq(input string req, input int act, input int expv);
      checks++;
      if (act != expv) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, expv);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic release_all();
      cs_n = 1'b1; rw_n = 1'b1; we_n = 1'b1;
   endtask

   // R9: view port read back entry by entry
   task automatic check_array(input string req);
      for (int i = 0; i < DEPTH; i++) begin
         peek_idx = 4'(i);
         tick();
         chk_eq(req, int'(peek_data), int'(exp_mem[i]));
      end
   endtask

   task automatic do_write(input logic [14:0] a, input logic [7:0] d,
                           input int hold, input bit mid, input bit cs_only);
      addr = a; din = d;
      cs_n = 1'b0; rw_n = 1'b0; we_n = 1'b0;
      for (int k = 1; k <= N + 1 + hold; k++) begin
         tick();
         chk_eq("R3", int'(rdy), (k >= N + 1) ? 1 : 0);
         if (mid && k == 1) begin
            addr = a ^ 15'd1;          // R4/R6: later bus values ignored
            din  = ~d;
         end
      end
      if (cs_only) cs_n = 1'b1;       // R5: release only chip select
      else release_all();
      tick();
      chk_eq("R5", int'(rdy), 0);
      release_all();
      if (a < 15'(DEPTH)) exp_mem[a[3:0]] = d;
   endtask

   task automatic abort_write(input logic [14:0] a, input logic [7:0] d);
      addr = a; din = d;
      cs_n = 1'b0; rw_n = 1'b0; we_n = 1'b0;
      tick();
      chk_eq("R7", int'(rdy), 0);
      we_n = 1'b1;
      tick();
      chk_eq("R7", int'(rdy), 0);
      release_all();
      repeat (N + 1) begin
         tick();
         chk_eq("R7", int'(rdy), 0);
      end
   endtask

   task automatic non_write(input logic c, input logic r, input logic w);
      addr = 15'd7; din = 8'hC3;
      cs_n = c; rw_n = r; we_n = w;
      repeat (N + 3) begin
         tick();
         chk_eq("R2", int'(rdy), 0);
      end
      release_all();
      tick();
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin : stim
      for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'h00;

      // R1 and R6: strobes already low while reset is applied
      addr = 15'd5; din = 8'h5A;
      cs_n = 1'b0; rw_n = 1'b0; we_n = 1'b0;
      repeat (3) tick();
      chk_eq("R1", int'(rdy), 0);
      rst = 1'b0;
      repeat (N + 4) begin
         tick();
         chk_eq("R6", int'(rdy), 0);
      end
      release_all();
      tick();
      check_array("R1");

      // R2: one strobe missing each time
      non_write(1'b0, 1'b1, 1'b0);
      non_write(1'b1, 1'b0, 1'b0);
      non_write(1'b0, 1'b0, 1'b1);
      check_array("R2");

      // R3/R4/R5: sweep all entries, back to back
      for (int a = 0; a < DEPTH; a++) begin
         do_write(15'(a), 8'((a * 37 + 5) & 8'hFF), a % 3, (a % 4) == 0,
                  (a % 2) == 1);
         if (a % 4 == 3) check_array("R4/R9");
      end

      // R6: long hold with changing bus, one commit only
      do_write(15'd6, 8'hA6, 6, 1'b1, 1'b0);
      check_array("R6");

      // R8: out-of-range addresses, one aliasing entry 5 in low bits
      do_write(15'd16, 8'h11, 0, 1'b0, 1'b0);
      do_write(15'h7FFF, 8'h22, 1, 1'b0, 1'b0);
      do_write(15'h4005, 8'h33, 0, 1'b0, 1'b0);
      check_array("R8");

      // R7: abandoned cycle
      abort_write(15'd3, 8'hEE);
      check_array("R7");

      // re-arm after abort works: R6
      do_write(15'd3, 8'h7C, 0, 1'b0, 1'b0);
      check_array("R6");

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule